// File: doc/BRIEF.md
# Pad Pull Configuration Register Block

This block holds the pull setting of every pad across several GPIO groups. Software writes 32-bit words. The upper half of each word selects which data bits the write changes, so one pin can be updated without first reading the register. Each pin has a 2-bit field. The block decodes that field into three enables: pull-up, pull-down and bus-keeper. It also contains a behavioural pad model that resolves a logic value for each pin from the driver, the pull mode and the keeper.

The register map has two regions. The first pins of group 0 sit in a small always-on region, and their fields are laid out in ascending pin order. Every other pin sits in the main region, where each register lists its eight pins in descending order. Reads return the stored fields of the addressed register in the lower half of the word and zero in the upper half. A read of the current `addr_i` is combinational.

Top module: `pad_pull_regs`

## Requirements
- R1: A write with `wr_en_i` high changes data bit n of the addressed register only when `wdata_i[16+n]` is 1. Each bit of a 2-bit field can be changed on its own.
- R2: Field encoding: 2'b00 is high impedance (no enable), 2'b01 is pull-up (`pull_up_o`), 2'b10 is pull-down (`pull_dn_o`) and 2'b11 is bus keeper (`keep_en_o`). At most one enable per pin is high.
- R3: Pins 0..AON_PINS-1 of group 0 live at addresses 0 and up. Pin p is at address p/8, bits 2*(p%8)+1 : 2*(p%8).
- R4: Every other pin p of group b lives at address MAIN_BASE + b*(PINS_PER_BANK/8) + p/8, bits 2*(7-p%8)+1 : 2*(7-p%8).
- R5: Slots of a mapped register that hold no pin read as zero, and writes to them have no effect. This covers the group-0 always-on pins at their reversed-region positions and the slots past AON_PINS in the last always-on register.
- R6: `rdata_o[15:0]` returns the stored fields of the register at `addr_i`, and `rdata_o[31:16]` is always zero.
- R7: An address that is neither an always-on register nor a main-region register reads zero, and a write to it changes no field.
- R8: After reset every field is 2'b00, all enables are low and every read returns zero.
- R9: In bus-keeper mode with `pad_oe_i` low, `pad_val_o` equals the `pad_do_i` value that was sampled at the last clock edge where `pad_oe_i` was high (0 if there was none since reset).
- R10: With `pad_oe_i` high, `pad_val_o` equals `pad_do_i`. When the pin is undriven: pull-up gives 1, pull-down gives 0, and high impedance gives `pad_float_o`=1 with `pad_val_o`=0. `pad_float_o` is 0 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Register word address for write and read |
| wdata_i | input | 32 | Mask (31:16) and data (15:0) |
| rdata_o | output | 32 | Read data for addr_i |
| pull_up_o | output | NUM_PINS | Pull-up enable per pin |
| pull_dn_o | output | NUM_PINS | Pull-down enable per pin |
| keep_en_o | output | NUM_PINS | Bus-keeper enable per pin |
| pad_oe_i | input | NUM_PINS | Pad driver enable (pad model) |
| pad_do_i | input | NUM_PINS | Pad driver value (pad model) |
| pad_val_o | output | NUM_PINS | Resolved pad logic value |
| pad_float_o | output | NUM_PINS | Pad undriven with no pull or keeper |

## Verification
A field stored in the wrong slot or at the wrong address shows up right away. It appears on the enable outputs of a pin other than the one intended, in the same cycle after the write edge, and a readback of either register exposes it. A mask decoded at the wrong bit leaves a half-updated field, which the next decode shows as the wrong mode. A stale keeper value only appears once a keeper-mode pin is released, so the bench releases pins right after driving each level.

// File: rtl/pull_pkg.sv
package pull_pkg;
  localparam logic [1:0] PULL_Z    = 2'b00;
  localparam logic [1:0] PULL_UP   = 2'b01;
  localparam logic [1:0] PULL_DN   = 2'b10;
  localparam logic [1:0] PULL_KEEP = 2'b11;

  function automatic bit pin_is_aon(int g, int ppb, int aon_pins);
    return (g / ppb == 0) && (g % ppb < aon_pins);
  endfunction

  function automatic int pin_reg(int g, int ppb, int aon_pins, int main_base);
    if (pin_is_aon(g, ppb, aon_pins)) return (g % ppb) / 8;
    return main_base + (g / ppb) * (ppb / 8) + (g % ppb) / 8;
  endfunction

  function automatic int pin_slot(int g, int ppb, int aon_pins);
    if (pin_is_aon(g, ppb, aon_pins)) return (g % ppb) % 8;
    return 7 - (g % ppb) % 8;
  endfunction
endpackage

// File: rtl/pull_decode.sv
module pull_decode
  import pull_pkg::*;
(
  input  logic [1:0] mode_i,
  output logic       up_o,
  output logic       dn_o,
  output logic       keep_o
);
  always_comb begin
    up_o   = (mode_i == PULL_UP);
    dn_o   = (mode_i == PULL_DN);
    keep_o = (mode_i == PULL_KEEP);
    assert_one_mode_R2: assert ($onehot0({up_o, dn_o, keep_o}));
  end
endmodule

// File: rtl/pad_keeper.sv
module pad_keeper (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_i,
  input  logic do_i,
  output logic held_o
);
  logic held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   held_q <= 1'b0;
    else if (oe_i) held_q <= do_i;
  end

  assign held_o = held_q;

  assert_keep_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |=> held_o == $past(do_i));
  assert_keep_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> $stable(held_o));
endmodule

// File: rtl/pull_pin.sv
module pull_pin
  import pull_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       hit_i,
  input  logic [1:0] wmask_i,
  input  logic [1:0] wdata_i,
  input  logic       pad_oe_i,
  input  logic       pad_do_i,
  output logic [1:0] mode_o,
  output logic       up_o,
  output logic       dn_o,
  output logic       keep_o,
  output logic       pad_val_o,
  output logic       pad_float_o
);
  logic [1:0] mode_q;
  logic       held;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= PULL_Z;
    else if (wr_en_i && hit_i) begin
      for (int i = 0; i < 2; i++)
        if (wmask_i[i]) mode_q[i] <= wdata_i[i];
    end
  end

  assign mode_o = mode_q;

  pull_decode i_dec (.mode_i(mode_q), .up_o(up_o), .dn_o(dn_o), .keep_o(keep_o));

  pad_keeper i_keep (
    .clk_i(clk_i), .rst_ni(rst_ni), .oe_i(pad_oe_i), .do_i(pad_do_i), .held_o(held)
  );

  always_comb begin
    pad_float_o = 1'b0;
    if (pad_oe_i)    pad_val_o = pad_do_i;
    else if (up_o)   pad_val_o = 1'b1;
    else if (keep_o) pad_val_o = held;
    else begin
      pad_val_o   = 1'b0;
      pad_float_o = !dn_o;
    end
  end

  assert_unselected_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && hit_i) |=> $stable(mode_o));
  assert_masked_bits_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit_i && wmask_i == 2'b00) |=> $stable(mode_o));
  assert_pad_driven_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_i |-> (pad_val_o == pad_do_i) && !pad_float_o);
endmodule

// File: rtl/pad_pull_regs.sv
module pad_pull_regs
  import pull_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int PINS_PER_BANK = 32,
  parameter int AON_PINS      = 12,
  parameter int MAIN_BASE     = 4,
  parameter int ADDR_W        = 5,
  localparam int NUM_PINS     = NUM_BANKS * PINS_PER_BANK
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic [NUM_PINS-1:0] pull_up_o,
  output logic [NUM_PINS-1:0] pull_dn_o,
  output logic [NUM_PINS-1:0] keep_en_o,
  input  logic [NUM_PINS-1:0] pad_oe_i,
  input  logic [NUM_PINS-1:0] pad_do_i,
  output logic [NUM_PINS-1:0] pad_val_o,
  output logic [NUM_PINS-1:0] pad_float_o
);
  logic [NUM_PINS-1:0]       hit;
  logic [NUM_PINS-1:0][15:0] rd_part;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    localparam int REG_ADDR = pin_reg(g, PINS_PER_BANK, AON_PINS, MAIN_BASE);
    localparam int SLOT     = pin_slot(g, PINS_PER_BANK, AON_PINS);
    logic [1:0] mode;

    assign hit[g] = (addr_i == ADDR_W'(REG_ADDR));

    pull_pin i_pin (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i),
      .hit_i      (hit[g]),
      .wmask_i    (wdata_i[16+2*SLOT +: 2]),
      .wdata_i    (wdata_i[2*SLOT +: 2]),
      .pad_oe_i   (pad_oe_i[g]),
      .pad_do_i   (pad_do_i[g]),
      .mode_o     (mode),
      .up_o       (pull_up_o[g]),
      .dn_o       (pull_dn_o[g]),
      .keep_o     (keep_en_o[g]),
      .pad_val_o  (pad_val_o[g]),
      .pad_float_o(pad_float_o[g])
    );

    assign rd_part[g] = hit[g] ? (16'(mode) << (2*SLOT)) : 16'h0000;
  end

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NUM_PINS; g++) rdata_o[15:0] = rdata_o[15:0] | rd_part[g];
  end

  assert_mask_half_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[31:16] == 16'h0000);
  assert_reset_clear_R8: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (rdata_o == 32'h0) && (pull_up_o == '0) && (pull_dn_o == '0)
                      && (keep_en_o == '0));
  assert_no_hit_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit == '0) |-> rdata_o == 32'h0);
endmodule

// File: tb/test_pad_pull_regs.sv
module test_pad_pull_regs;
  localparam int NB = 4, PPB = 32, AON = 12, MB = 4, AW = 5;
  localparam int NP = NB * PPB;

  logic clk = 1'b0, rst_ni = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NP-1:0] up, dn, kp, oe = '0, dout = '0, pval, pflt;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [1:0] model [NP];

  always #10 clk = ~clk;

  pad_pull_regs #(.NUM_BANKS(NB), .PINS_PER_BANK(PPB), .AON_PINS(AON), .MAIN_BASE(MB),
                  .ADDR_W(AW)) i_pad_pull_regs (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pull_up_o(up), .pull_dn_o(dn), .keep_en_o(kp),
    .pad_oe_i(oe), .pad_do_i(dout), .pad_val_o(pval), .pad_float_o(pflt)
  );

  function automatic int e_addr(int g);
    int b = g / PPB, p = g % PPB;
    if (b == 0 && p < AON) return p / 8;
    return MB + b * (PPB / 8) + p / 8;
  endfunction

  function automatic int e_slot(int g);
    int b = g / PPB, p = g % PPB;
    if (b == 0 && p < AON) return p % 8;
    return 7 - p % 8;
  endfunction

  function automatic logic [31:0] e_rdata(int a);
    logic [31:0] r = '0;
    for (int g = 0; g < NP; g++)
      if (e_addr(g) == a) r[2*e_slot(g) +: 2] = model[g];
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    for (int g = 0; g < NP; g++)
      if (e_addr(g) == a)
        for (int i = 0; i < 2; i++)
          if (d[16 + 2*e_slot(g) + i]) model[g][i] = d[2*e_slot(g) + i];
  endtask

  task automatic rd_chk(int a, string req);
    addr = AW'(a);
    #1;
    chk(rdata == e_rdata(a), req, rdata, e_rdata(a));
  endtask

  task automatic outs_chk(string req);
    for (int g = 0; g < NP; g++) begin
      logic [2:0] e = {model[g] == 2'b01, model[g] == 2'b10, model[g] == 2'b11};
      chk({up[g], dn[g], kp[g]} == e, req, 32'({up[g], dn[g], kp[g]}), 32'(e));
    end
  endtask

  // R10: expected pad value for non-keeper or driven pins
  task automatic pad_chk(string req);
    #1;
    for (int g = 0; g < NP; g++) begin
      logic ev, ef;
      if (!oe[g] && model[g] == 2'b11) continue;
      ef = 1'b0;
      if (oe[g]) ev = dout[g];
      else if (model[g] == 2'b01) ev = 1'b1;
      else begin ev = 1'b0; ef = (model[g] == 2'b00); end
      chk({pval[g], pflt[g]} == {ev, ef}, req, 32'({pval[g], pflt[g]}), 32'({ev, ef}));
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int g = 0; g < NP; g++) model[g] = 2'b00;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R8: reset state
    for (int a = 0; a < 32; a++) rd_chk(a, "R8");
    outs_chk("R8");
    chk(pflt == '1, "R8", 32'(pflt[31:0]), 32'hffffffff);

    // R3: always-on standard order, pin 0 pull-up
    wr(0, {16'h0003, 16'h0001});
    chk(up[0] && !dn[0] && !kp[0], "R3", 32'(up[0]), 1);
    rd_chk(0, "R3");
    // R1: change only high bit of pin 0 field -> keeper
    wr(0, {16'h0002, 16'hffff});
    chk(kp[0] && !up[0], "R1", 32'({up[0], kp[0]}), 32'b01);
    chk(model[1] == 2'b00 && !up[1] && !dn[1] && !kp[1], "R1", 32'({up[1], dn[1], kp[1]}), 0);
    // R3: pin 9 at address 1, bits 3:2
    wr(1, {16'h000c, 16'h0008});
    chk(dn[9], "R3", 32'(dn[9]), 1);
    // R4: group 1 pin 0 at top slot of address MB+4
    wr(MB + 4, {16'hc000, 16'h8000});
    chk(dn[32], "R4", 32'(dn[32]), 1);
    chk(!dn[39] && !up[39] && !kp[39], "R4", 32'({up[39], dn[39], kp[39]}), 0);
    wr(MB + 4, {16'h0003, 16'h0001});
    chk(up[39], "R4", 32'(up[39]), 1);
    rd_chk(MB + 4, "R4");
    // R5: empty slots
    wr(MB, 32'hffffffff);
    rd_chk(MB, "R5");
    chk(rdata == 32'h0, "R5", rdata, 0);
    wr(MB + 1, 32'hffffffff);
    rd_chk(MB + 1, "R5");
    chk(rdata == 32'h000000ff, "R5", rdata, 32'h000000ff);
    wr(1, 32'hffffffff);
    rd_chk(1, "R5");
    chk(rdata == 32'h000000ff, "R5", rdata, 32'h000000ff);
    outs_chk("R5");
    // R7: unmapped addresses
    wr(2, 32'hffffffff);
    wr(31, 32'hffffffff);
    rd_chk(2, "R7");
    rd_chk(31, "R7");
    chk(rdata == 32'h0, "R7", rdata, 0);
    outs_chk("R7");

    // random writes with R1/R6 checks
    for (int n = 0; n < 300; n++) begin
      int a = int'($urandom_range(0, 31));
      wr(a, $urandom());
      if (n % 20 == 0) outs_chk("R2");
      rd_chk(int'($urandom_range(0, 31)), "R6");
      chk(rdata[31:16] == 16'h0, "R6", rdata, {16'h0, rdata[15:0]});
    end
    outs_chk("R1");

    // random pad drive, R10
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      oe = {$urandom(), $urandom(), $urandom(), $urandom()};
      dout = {$urandom(), $urandom(), $urandom(), $urandom()};
      pad_chk("R10");
    end
    @(negedge clk);
    oe = '0;

    // R9: keeper on pin 40, R10 pulls on pins 41..43
    wr(MB + 5, {16'hff00, 16'hf9c0}); // slot7=11 (p40), slot6=10? recompute below
    // force exact modes: p40 keep, p41 up, p42 down, p43 Z
    wr(MB + 5, {16'hff00, 16'b11_01_10_00_00000000});
    chk(kp[40] && up[41] && dn[42] && !up[43] && !dn[43] && !kp[43], "R2",
        32'({kp[40], up[41], dn[42]}), 32'b111);
    @(negedge clk); oe[40] = 1'b1; dout[40] = 1'b1;
    @(negedge clk); oe[40] = 1'b0; dout[40] = 1'b0;
    #1 chk(pval[40] == 1'b1 && !pflt[40], "R9", 32'(pval[40]), 1);
    repeat (3) @(negedge clk);
    chk(pval[40] == 1'b1, "R9", 32'(pval[40]), 1);
    oe[40] = 1'b1; dout[40] = 1'b0;
    @(negedge clk); oe[40] = 1'b0; dout[40] = 1'b1;
    #1 chk(pval[40] == 1'b0, "R9", 32'(pval[40]), 0);
    chk(pval[41] == 1'b1 && !pflt[41], "R10", 32'({pval[41], pflt[41]}), 32'b10);
    chk(pval[42] == 1'b0 && !pflt[42], "R10", 32'({pval[42], pflt[42]}), 32'b00);
    chk(pval[43] == 1'b0 && pflt[43], "R10", 32'({pval[43], pflt[43]}), 32'b01);
    pad_chk("R10");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule